// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry-Out

This block is a purely combinational shifter that sits in front of the second ALU input of a 32-bit data path. It takes a register value, a two-bit shift kind, a shift amount and the current carry flag. It returns the shifted operand and the carry that the shift produces. The form select chooses where the shift distance comes from:

- a five-bit amount taken from the instruction;
- an eight-bit amount read from a register;
- a rotated eight-bit immediate.

In the immediate form, several zero-distance encodings have meanings of their own. An amount of zero turns a right shift into a full-width shift, and it turns a rotate into a one-bit rotate through the carry. The carry-out is worked out separately for every such case. Register access, the ALU itself and flag storage sit outside the block.

Top module: `opnd_shifter`

## Requirements
- R1: Shift kind encoding is 0 = logical left, 1 = logical right, 2 = arithmetic right, 3 = rotate right. A logical-left shift by a nonzero distance n below 32 yields the value shifted left, and the carry-out is bit 32-n of the input.
- R2: Logical-right, arithmetic-right and rotate-right shifts by a nonzero distance n below 32 give the expected result, and the carry-out is input bit n-1.
- R3: Form 0 (immediate amount), logical left, amount 0: the value passes unchanged and the carry-out equals carry_in.
- R4: Form 0 with a logical-right or arithmetic-right kind and amount 0 acts as a shift by 32. Logical right gives 0 with carry-out equal to bit 31. Arithmetic right gives 32 copies of bit 31, with carry-out equal to bit 31.
- R5: Form 0, rotate right, amount 0 is a one-bit rotate through carry. The result is {carry_in, value[31:1]} and the carry-out is value[0].
- R6: Form 1 (register amount) with an 8-bit amount of 0 leaves the value unchanged, and the carry-out equals carry_in, for every shift kind.
- R7: Form 1 logical shifts by exactly 32 give 0, with carry-out equal to value[0] for left and value[31] for right. Logical shifts by more than 32 give 0 with carry-out 0.
- R8: An arithmetic-right shift by 32 or more fills the result with bit 31, and the carry-out equals bit 31.
- R9: A form 1 rotate by a nonzero amount uses the amount modulo 32. When that is 0, the value is unchanged and the carry-out is value[31].
- R10: Form 2 or 3 (rotated immediate) takes value[7:0], zero-extends it and rotates it right by twice the 4-bit rotate field. Shift kind and both amounts are ignored. The carry-out is carry_in when the field is 0, otherwise result bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | 32 | Operand value (low 8 bits are the immediate in forms 2/3) |
| kind_i | input | 2 | Shift kind |
| imm_amt_i | input | 5 | Immediate shift amount (form 0) |
| reg_amt_i | input | 8 | Register shift amount (form 1) |
| form_i | input | 2 | Operand form: 0 immediate amount, 1 register amount, 2/3 rotated immediate |
| rot_i | input | 4 | Rotate field for the rotated immediate |
| carry_i | input | 1 | Current carry flag |
| res_o | output | 32 | Shifted operand |
| carry_o | output | 1 | Shifter carry-out |

## Verification
The block holds no state, so any fault shows up at res_o or carry_o as soon as the inputs settle, within the same cycle. The risky faults are all in the distance decode. A zero distance taken for a real shift, a dropped eighth amount bit, or a wrong carry index each corrupts one output for only a narrow band of inputs. The directed vectors therefore sit on those bands: zero, 32, just above 32, the top of the 8-bit range, and multiples of 32 for rotates.

// File: rtl/opnd_shifter.sv
module opnd_shifter #(
  parameter int W   = 32,
  parameter int RAW = 8,
  localparam int LW = $clog2(W)
) (
  input  logic [W-1:0]   opnd_i,
  input  logic [1:0]     kind_i,
  input  logic [LW-1:0]  imm_amt_i,
  input  logic [RAW-1:0] reg_amt_i,
  input  logic [1:0]     form_i,
  input  logic [LW-2:0]  rot_i,
  input  logic           carry_i,
  output logic [W-1:0]   res_o,
  output logic           carry_o
);
  localparam int NW = (RAW > LW + 1) ? RAW : LW + 1;
  localparam logic [1:0] K_LSL = 2'd0, K_LSR = 2'd1, K_ASR = 2'd2, K_ROR = 2'd3;

  logic          imm_form, reg_form, rimm_form;
  logic [NW-1:0] n;
  logic [W:0]    lsl_w, lsr_w, asr_w;
  logic [W-1:0]  ror_v, rimm_v, imm8;

  assign imm_form  = (form_i == 2'd0);
  assign reg_form  = (form_i == 2'd1);
  assign rimm_form = form_i[1];

  always_comb begin
    if (reg_form)
      n = NW'(reg_amt_i);
    else if (imm_amt_i == '0 && (kind_i == K_LSR || kind_i == K_ASR))
      n = NW'(W);
    else
      n = NW'(imm_amt_i);
  end

  assign lsl_w = {1'b0, opnd_i} << n;
  assign lsr_w = {opnd_i, 1'b0} >> n;
  assign asr_w = $signed({opnd_i, 1'b0}) >>> n;
  assign ror_v = W'({opnd_i, opnd_i} >> n[LW-1:0]);
  assign imm8  = {{(W-8){1'b0}}, opnd_i[7:0]};
  assign rimm_v = W'({imm8, imm8} >> {rot_i, 1'b0});

  always_comb begin
    res_o   = opnd_i;
    carry_o = carry_i;
    if (rimm_form) begin
      res_o   = rimm_v;
      carry_o = (rot_i == '0) ? carry_i : rimm_v[W-1];
    end else if (n == '0) begin
      if (imm_form && kind_i == K_ROR) begin
        res_o   = {carry_i, opnd_i[W-1:1]};
        carry_o = opnd_i[0];
      end
    end else begin
      unique case (kind_i)
        K_LSL: begin res_o = lsl_w[W-1:0]; carry_o = lsl_w[W];   end
        K_LSR: begin res_o = lsr_w[W:1];   carry_o = lsr_w[0];   end
        K_ASR: begin res_o = asr_w[W:1];   carry_o = asr_w[0];   end
        K_ROR: begin res_o = ror_v;        carry_o = ror_v[W-1]; end
      endcase
    end
  end

  always_comb begin
    if (!$isunknown({opnd_i, kind_i, imm_amt_i, reg_amt_i, form_i, rot_i, carry_i})) begin
      // R6
      reg_zero_chk: assert (!(reg_form && reg_amt_i == '0) ||
                            (res_o == opnd_i && carry_o == carry_i));
      // R7
      wide_logical_chk: assert (!(reg_form && !kind_i[1] && reg_amt_i > RAW'(W)) ||
                                (res_o == '0 && !carry_o));
      // R8
      asr_fill_chk: assert (!(reg_form && kind_i == K_ASR && reg_amt_i >= RAW'(W)) ||
                            (res_o == {W{opnd_i[W-1]}} && carry_o == opnd_i[W-1]));
      // R5
      rrx_chk: assert (!(imm_form && kind_i == K_ROR && imm_amt_i == '0) ||
                       (res_o[W-1] == carry_i && carry_o == opnd_i[0]));
      // R10
      rimm_bits_chk: assert (!rimm_form ||
                             $countones(res_o) == $countones(opnd_i[7:0]));
      // R2
      ror_bits_chk: assert (!(!rimm_form && kind_i == K_ROR && n != '0) ||
                            ($countones(res_o) == $countones(opnd_i) && carry_o == res_o[W-1]));
    end
  end
endmodule

// File: tb/opnd_shifter_bench.sv
module opnd_shifter_bench;
  logic        clk = 1'b0;
  logic [31:0] v = '0;
  logic [1:0]  kind = '0;
  logic [4:0]  ia = '0;
  logic [7:0]  ra = '0;
  logic [1:0]  form = '0;
  logic [3:0]  rot = '0;
  logic        cin = 1'b0;
  logic [31:0] res;
  logic        cout;
  int total = 0;
  int fails = 0;

  always #5 clk = ~clk;

  opnd_shifter u_opnd_shifter (
    .opnd_i(v), .kind_i(kind), .imm_amt_i(ia), .reg_amt_i(ra),
    .form_i(form), .rot_i(rot), .carry_i(cin), .res_o(res), .carry_o(cout)
  );

  task automatic apply(input logic [1:0] f, input logic [1:0] k, input logic [31:0] val,
                       input logic [4:0] i_a, input logic [7:0] r_a,
                       input logic [3:0] r, input logic c);
    @(posedge clk);
    form = f; kind = k; v = val; ia = i_a; ra = r_a; rot = r; cin = c;
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] er, input logic ec);
    total++;
    if (res !== er || cout !== ec) begin
      fails++;
      $display("FAIL %s: res=%h carry=%b expected res=%h carry=%b", req, res, cout, er, ec);
    end
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    chk("R3", 32'h0, 1'b0);
  endtask

  task automatic t_r1_lsl();
    apply(2'd0, 2'd0, 32'hF000_0001, 5'd4, 8'd0, 4'd0, 1'b0); chk("R1", 32'h0000_0010, 1'b1);
    apply(2'd1, 2'd0, 32'h8000_0001, 5'd0, 8'd1, 4'd0, 1'b0); chk("R1", 32'h0000_0002, 1'b1);
  endtask

  task automatic t_r2_right();
    apply(2'd0, 2'd1, 32'h1234_5680, 5'd8, 8'd0, 4'd0, 1'b0); chk("R2", 32'h0012_3456, 1'b1);
    apply(2'd0, 2'd2, 32'h8000_0018, 5'd4, 8'd0, 4'd0, 1'b0); chk("R2", 32'hF800_0001, 1'b1);
    apply(2'd0, 2'd3, 32'h1234_5678, 5'd8, 8'd0, 4'd0, 1'b1); chk("R2", 32'h7812_3456, 1'b0);
  endtask

  task automatic t_r3_lsl_zero();
    apply(2'd0, 2'd0, 32'hDEAD_BEEF, 5'd0, 8'd7, 4'd0, 1'b1); chk("R3", 32'hDEAD_BEEF, 1'b1);
    apply(2'd0, 2'd0, 32'hDEAD_BEEF, 5'd0, 8'd7, 4'd0, 1'b0); chk("R3", 32'hDEAD_BEEF, 1'b0);
  endtask

  task automatic t_r4_imm_zero_right();
    apply(2'd0, 2'd1, 32'h8000_0001, 5'd0, 8'd0, 4'd0, 1'b0); chk("R4", 32'h0, 1'b1);
    apply(2'd0, 2'd2, 32'h8000_0000, 5'd0, 8'd0, 4'd0, 1'b0); chk("R4", 32'hFFFF_FFFF, 1'b1);
    apply(2'd0, 2'd2, 32'h7FFF_FFFF, 5'd0, 8'd0, 4'd0, 1'b1); chk("R4", 32'h0, 1'b0);
  endtask

  task automatic t_r5_rrx();
    apply(2'd0, 2'd3, 32'h0000_0003, 5'd0, 8'd0, 4'd0, 1'b1); chk("R5", 32'h8000_0001, 1'b1);
    apply(2'd0, 2'd3, 32'h0000_0002, 5'd0, 8'd0, 4'd0, 1'b0); chk("R5", 32'h0000_0001, 1'b0);
  endtask

  task automatic t_r6_reg_zero();
    apply(2'd1, 2'd3, 32'h1234_5678, 5'd9, 8'd0, 4'd0, 1'b1); chk("R6", 32'h1234_5678, 1'b1);
    apply(2'd1, 2'd1, 32'h1234_5678, 5'd0, 8'd0, 4'd0, 1'b0); chk("R6", 32'h1234_5678, 1'b0);
    apply(2'd1, 2'd2, 32'h8000_0000, 5'd0, 8'd0, 4'd0, 1'b1); chk("R6", 32'h8000_0000, 1'b1);
  endtask

  task automatic t_r7_wide_logical();
    apply(2'd1, 2'd0, 32'h0000_0001, 5'd0, 8'd32,  4'd0, 1'b0); chk("R7", 32'h0, 1'b1);
    apply(2'd1, 2'd1, 32'h8000_0000, 5'd0, 8'd32,  4'd0, 1'b0); chk("R7", 32'h0, 1'b1);
    apply(2'd1, 2'd0, 32'hFFFF_FFFF, 5'd0, 8'd33,  4'd0, 1'b1); chk("R7", 32'h0, 1'b0);
    apply(2'd1, 2'd1, 32'hFFFF_FFFF, 5'd0, 8'd200, 4'd0, 1'b1); chk("R7", 32'h0, 1'b0);
  endtask

  task automatic t_r8_asr_fill();
    apply(2'd1, 2'd2, 32'h8000_0000, 5'd0, 8'd40,  4'd0, 1'b0); chk("R8", 32'hFFFF_FFFF, 1'b1);
    apply(2'd1, 2'd2, 32'h4000_0000, 5'd0, 8'd255, 4'd0, 1'b1); chk("R8", 32'h0, 1'b0);
    apply(2'd1, 2'd2, 32'h8000_0001, 5'd0, 8'd32,  4'd0, 1'b0); chk("R8", 32'hFFFF_FFFF, 1'b1);
  endtask

  task automatic t_r9_ror_mod();
    apply(2'd1, 2'd3, 32'h0000_00F1, 5'd0, 8'd36, 4'd0, 1'b1); chk("R9", 32'h1000_000F, 1'b0);
    apply(2'd1, 2'd3, 32'h8000_0001, 5'd0, 8'd64, 4'd0, 1'b0); chk("R9", 32'h8000_0001, 1'b1);
    apply(2'd1, 2'd3, 32'h7000_0000, 5'd0, 8'd32, 4'd0, 1'b1); chk("R9", 32'h7000_0000, 1'b0);
  endtask

  task automatic t_r10_rot_imm();
    apply(2'd2, 2'd2, 32'hFFFF_FFAB, 5'd3, 8'd9, 4'd0,  1'b1); chk("R10", 32'h0000_00AB, 1'b1);
    apply(2'd2, 2'd1, 32'hFFFF_FFAB, 5'd0, 8'd0, 4'd4,  1'b0); chk("R10", 32'hAB00_0000, 1'b1);
    apply(2'd2, 2'd0, 32'h0000_0003, 5'd7, 8'd5, 4'd1,  1'b0); chk("R10", 32'hC000_0000, 1'b1);
    apply(2'd3, 2'd3, 32'h5555_5581, 5'd1, 8'd1, 4'd15, 1'b1); chk("R10", 32'h0000_0204, 1'b0);
  endtask

  initial begin
    #2_000_000;
    total++;
    fails++;
    $display("FAIL watchdog: res=%h carry=%b expected completion", res, cout);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    t_reset_state();
    t_r1_lsl();
    t_r2_right();
    t_r3_lsl_zero();
    t_r4_imm_zero_right();
    t_r5_rrx();
    t_r6_reg_zero();
    t_r7_wide_logical();
    t_r8_asr_fill();
    t_r9_ror_mod();
    t_r10_rot_imm();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule